// File: doc/BRIEF.md
# Dual-Mode MD5 / HAS-160 Hash Core

This block computes either an MD5 or a HAS-160 message digest. A single working datapath and one 16-word message store serve both algorithms. The host pulses `start_i` with `mode_i` set to pick the algorithm. This loads the chaining state with that algorithm's standard initial value.

The host then feeds pre-padded 512-bit blocks as sixteen 32-bit words on `blk_word_i`, qualified by `blk_valid_i`. It flags the final block of the message with `blk_last_i` on that block's sixteenth word. Padding and length encoding happen upstream.

After the sixteenth word the core raises `busy_o` and runs one compression step per clock:
- 64 steps in MD5 mode.
- 80 steps in HAS-160 mode.

At the end of each block the working registers are added back into the chaining state. After the last block, `done_o` pulses and `digest_o` presents the result. The result is 128 bits for MD5 and 160 bits for HAS-160.

Top module: `hash_dual_core`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `busy_o` and `done_o` are 0 and `digest_o` is all zeros.
- R2: In MD5 mode (`mode_i` = 0 at start), the final digest of a padded message equals the standard MD5 value.
  - `digest_o[127:0]` read as a hex string, most significant nibble first, gives the conventional digest text.
  - `digest_o[159:128]` is zero.
- R3: In HAS-160 mode (`mode_i` = 1 at start), `digest_o[159:0]` read as a hex string, most significant nibble first, equals the standard HAS-160 digest of the message.
- R4: A message of several blocks is hashed correctly. Each block starts from the chaining state left by the previous one, and that state is summed word-wise with the working registers at the end of every block.
- R5: `start_i` accepted while idle reloads the chaining state with the initial value of the selected algorithm and latches the mode. Changes on `mode_i` after that have no effect on the running hash.
- R6: `busy_o` rises in the cycle after the sixteenth word of a block is accepted. It stays high for exactly 64 cycles (MD5) or 80 cycles (HAS-160), and it is never high together with `done_o`.
- R7: `done_o` is a one-cycle pulse in the cycle right after the final step of a block flagged last. Non-last blocks produce no pulse.
- R8: While `busy_o` is high, `blk_valid_i`, `blk_word_i` and `start_i` are ignored. They neither change the stored block, the word count nor the chaining state.
- R9: `digest_o` changes only in a cycle where `done_o` is high, and holds its value until the next such cycle.
- R10: Each accepted word is one message word: byte 4n of the block is bits [7:0] of word n and byte 4n+3 is bits [31:24]. Words are numbered in arrival order, 0 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new message (accepted only while idle) |
| mode_i | input | 1 | Algorithm select sampled at start: 0 MD5, 1 HAS-160 |
| blk_valid_i | input | 1 | Qualifies `blk_word_i` |
| blk_word_i | input | 32 | Message word, little-endian byte packing |
| blk_last_i | input | 1 | Marks the current block as the message's last; sampled with the 16th word |
| busy_o | output | 1 | Compression in progress |
| done_o | output | 1 | One-cycle pulse: digest valid |
| digest_o | output | 160 | Digest; MD5 uses bits [127:0] |

## Verification
The bound checker watches the handshake shape on every cycle:
- the exact busy length per mode;
- the single-cycle done pulse that always follows a busy cycle;
- mutual exclusion of busy and done;
- a digest that moves only with done;
- zero upper bits in MD5 mode.

Only the bench scenarios can show that the digest values are right. They compare against fixed answers for short messages and against an independent arithmetic model over a sweep of lengths crossing one, two and three blocks. They also drive mode flips and start pulses while the core works, and confirm that words fed during compression leave the result unchanged.

// File: rtl/hash_pkg.sv
package hash_pkg;
  localparam int WORD_W      = 32;
  localparam int BLK_WORDS   = 16;
  localparam int STATE_WORDS = 5;
  localparam int MD5_STEPS   = 64;
  localparam int HAS_STEPS   = 80;
  localparam int DIG_W       = WORD_W * STATE_WORDS;

  typedef enum logic {ALG_MD5 = 1'b0, ALG_HAS = 1'b1} alg_e;

  function automatic logic [31:0] rotl32(input logic [31:0] x, input logic [4:0] s);
    logic [63:0] d;
    d = {x, x} << s;
    return d[63:32];
  endfunction

  function automatic logic [31:0] bswap32(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic [31:0] iv_word(input alg_e alg, input int n);
    case (n)
      0: return 32'h67452301;
      1: return 32'hefcdab89;
      2: return 32'h98badcfe;
      3: return 32'h10325476;
      default: return (alg == ALG_HAS) ? 32'hc3d2e1f0 : 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] md5_k(input logic [5:0] i);
    case (i)
      6'd0:  return 32'hd76aa478; 6'd1:  return 32'he8c7b756; 6'd2:  return 32'h242070db; 6'd3:  return 32'hc1bdceee;
      6'd4:  return 32'hf57c0faf; 6'd5:  return 32'h4787c62a; 6'd6:  return 32'ha8304613; 6'd7:  return 32'hfd469501;
      6'd8:  return 32'h698098d8; 6'd9:  return 32'h8b44f7af; 6'd10: return 32'hffff5bb1; 6'd11: return 32'h895cd7be;
      6'd12: return 32'h6b901122; 6'd13: return 32'hfd987193; 6'd14: return 32'ha679438e; 6'd15: return 32'h49b40821;
      6'd16: return 32'hf61e2562; 6'd17: return 32'hc040b340; 6'd18: return 32'h265e5a51; 6'd19: return 32'he9b6c7aa;
      6'd20: return 32'hd62f105d; 6'd21: return 32'h02441453; 6'd22: return 32'hd8a1e681; 6'd23: return 32'he7d3fbc8;
      6'd24: return 32'h21e1cde6; 6'd25: return 32'hc33707d6; 6'd26: return 32'hf4d50d87; 6'd27: return 32'h455a14ed;
      6'd28: return 32'ha9e3e905; 6'd29: return 32'hfcefa3f8; 6'd30: return 32'h676f02d9; 6'd31: return 32'h8d2a4c8a;
      6'd32: return 32'hfffa3942; 6'd33: return 32'h8771f681; 6'd34: return 32'h6d9d6122; 6'd35: return 32'hfde5380c;
      6'd36: return 32'ha4beea44; 6'd37: return 32'h4bdecfa9; 6'd38: return 32'hf6bb4b60; 6'd39: return 32'hbebfbc70;
      6'd40: return 32'h289b7ec6; 6'd41: return 32'heaa127fa; 6'd42: return 32'hd4ef3085; 6'd43: return 32'h04881d05;
      6'd44: return 32'hd9d4d039; 6'd45: return 32'he6db99e5; 6'd46: return 32'h1fa27cf8; 6'd47: return 32'hc4ac5665;
      6'd48: return 32'hf4292244; 6'd49: return 32'h432aff97; 6'd50: return 32'hab9423a7; 6'd51: return 32'hfc93a039;
      6'd52: return 32'h655b59c3; 6'd53: return 32'h8f0ccc92; 6'd54: return 32'hffeff47d; 6'd55: return 32'h85845dd1;
      6'd56: return 32'h6fa87e4f; 6'd57: return 32'hfe2ce6e0; 6'd58: return 32'ha3014314; 6'd59: return 32'h4e0811a1;
      6'd60: return 32'hf7537e82; 6'd61: return 32'hbd3af235; 6'd62: return 32'h2ad7d2bb; default: return 32'heb86d391;
    endcase
  endfunction

  function automatic logic [4:0] md5_rot(input logic [1:0] rnd, input logic [1:0] col);
    case ({rnd, col})
      4'h0: return 5'd7;  4'h1: return 5'd12; 4'h2: return 5'd17; 4'h3: return 5'd22;
      4'h4: return 5'd5;  4'h5: return 5'd9;  4'h6: return 5'd14; 4'h7: return 5'd20;
      4'h8: return 5'd4;  4'h9: return 5'd11; 4'ha: return 5'd16; 4'hb: return 5'd23;
      4'hc: return 5'd6;  4'hd: return 5'd10; 4'he: return 5'd15; default: return 5'd21;
    endcase
  endfunction

  function automatic logic [4:0] has_rot_a(input logic [4:0] j);
    case (j)
      5'd0:  return 5'd5;  5'd1:  return 5'd11; 5'd2:  return 5'd7;  5'd3:  return 5'd15;
      5'd4:  return 5'd6;  5'd5:  return 5'd13; 5'd6:  return 5'd8;  5'd7:  return 5'd14;
      5'd8:  return 5'd7;  5'd9:  return 5'd12; 5'd10: return 5'd9;  5'd11: return 5'd11;
      5'd12: return 5'd8;  5'd13: return 5'd15; 5'd14: return 5'd6;  5'd15: return 5'd12;
      5'd16: return 5'd9;  5'd17: return 5'd14; 5'd18: return 5'd5;  default: return 5'd13;
    endcase
  endfunction

  function automatic logic [4:0] has_rot_b(input logic [1:0] rnd);
    case (rnd)
      2'd0: return 5'd10; 2'd1: return 5'd17; 2'd2: return 5'd25; default: return 5'd30;
    endcase
  endfunction

  function automatic logic [31:0] has_k(input logic [1:0] rnd);
    case (rnd)
      2'd0: return 32'h00000000; 2'd1: return 32'h5a827999;
      2'd2: return 32'h6ed9eba1; default: return 32'h8f1bbcdc;
    endcase
  endfunction
endpackage

// File: rtl/hash_msg_buf.sv
module hash_msg_buf #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int RP    = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [W-1:0]         wdata,
  input  logic [RP-1:0][AW-1:0] raddr,
  output logic [RP-1:0][W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < RP; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/hash_sched.sv
module hash_sched
  import hash_pkg::*;
#(
  parameter int STEP_W = 7,
  parameter int AW     = 4
) (
  input  alg_e                  alg,
  input  logic [STEP_W-1:0]     step,
  output logic [3:0][AW-1:0]    rd_idx,
  output logic                  xor_en,
  output logic [1:0]            rnd,
  output logic [4:0]            rot_a,
  output logic [4:0]            rot_b,
  output logic [31:0]           kc
);
  logic [4:0]    j;
  logic [1:0]    grp;
  logic [2:0]    j5;
  logic [AW-1:0] mult, off, k, md_idx;
  logic [1:0]    q;

  always_comb begin
    j = '0; grp = '0; j5 = '0; mult = '0; off = '0; k = '0; q = '0; md_idx = '0;
    xor_en = 1'b0; rnd = '0; rot_a = '0; rot_b = '0; kc = '0;
    rd_idx = '0;
    if (alg == ALG_MD5) begin
      rnd = step[5:4];
      case (rnd)
        2'd0: md_idx = step[3:0];
        2'd1: md_idx = 4'd5 * step[3:0] + 4'd1;
        2'd2: md_idx = 4'd3 * step[3:0] + 4'd5;
        default: md_idx = 4'd7 * step[3:0];
      endcase
      for (int p = 0; p < 4; p++) rd_idx[p] = md_idx;
      rot_a = md5_rot(rnd, step[1:0]);
      kc    = md5_k(step[5:0]);
    end else begin
      if (step < 7'd20)      begin rnd = 2'd0; j = 5'(step); end
      else if (step < 7'd40) begin rnd = 2'd1; j = 5'(step - 7'd20); end
      else if (step < 7'd60) begin rnd = 2'd2; j = 5'(step - 7'd40); end
      else                   begin rnd = 2'd3; j = 5'(step - 7'd60); end
      grp = (j < 5'd5) ? 2'd0 : (j < 5'd10) ? 2'd1 : (j < 5'd15) ? 2'd2 : 2'd3;
      j5  = 3'(j - 5'({grp, 2'b00}) - 5'(grp));
      case (rnd)
        2'd0: begin mult = 4'd1;  off = 4'd0;  end
        2'd1: begin mult = 4'd3;  off = 4'd3;  end
        2'd2: begin mult = 4'd9;  off = 4'd12; end
        default: begin mult = 4'd11; off = 4'd7; end
      endcase
      if (j5 == 3'd0) begin
        xor_en = 1'b1;
        q = grp + 2'd2;
        for (int p = 0; p < 4; p++) rd_idx[p] = mult * {q, 2'(p)} + off;
      end else begin
        k = {grp, 2'b00} + 4'(j5) - 4'd1;
        for (int p = 0; p < 4; p++) rd_idx[p] = mult * k + off;
      end
      rot_a = has_rot_a(j);
      rot_b = has_rot_b(rnd);
      kc    = has_k(rnd);
    end
  end
endmodule

// File: rtl/hash_step.sv
module hash_step
  import hash_pkg::*;
(
  input  alg_e             alg,
  input  logic [1:0]       rnd,
  input  logic [4:0]       rot_a,
  input  logic [4:0]       rot_b,
  input  logic [31:0]      kc,
  input  logic [31:0]      xw,
  input  logic [4:0][31:0] cur,
  output logic [4:0][31:0] nxt
);
  logic [31:0] a, b, c, d, e, f, t;

  always_comb begin
    a = cur[0]; b = cur[1]; c = cur[2]; d = cur[3]; e = cur[4];
    if (alg == ALG_MD5) begin
      case (rnd)
        2'd0: f = (b & c) | (~b & d);
        2'd1: f = (d & b) | (~d & c);
        2'd2: f = b ^ c ^ d;
        default: f = c ^ (b | ~d);
      endcase
      t = a + f + kc + xw;
      nxt[0] = d;
      nxt[1] = b + rotl32(t, rot_a);
      nxt[2] = b;
      nxt[3] = c;
      nxt[4] = e;
    end else begin
      case (rnd)
        2'd0: f = (b & c) | (~b & d);
        2'd2: f = c ^ (b | ~d);
        default: f = b ^ c ^ d;
      endcase
      t = rotl32(a, rot_a) + f + e + xw + kc;
      nxt[0] = t;
      nxt[1] = a;
      nxt[2] = rotl32(b, rot_b);
      nxt[3] = c;
      nxt[4] = d;
    end
  end
endmodule

// File: rtl/hash_dual_core.sv
module hash_dual_core
  import hash_pkg::*;
#(
  parameter int W       = 32,
  parameter int NWORDS  = 16,
  parameter int STEP_W  = 7,
  localparam int AW     = $clog2(NWORDS),
  localparam int DW     = 5 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic          blk_valid_i,
  input  logic [W-1:0]  blk_word_i,
  input  logic          blk_last_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] digest_o
);
  alg_e               alg_q;
  logic               busy_q, done_q, last_q;
  logic [AW-1:0]      wcnt;
  logic [STEP_W-1:0]  step, last_step;
  logic [4:0][31:0]   chain, work, nxt, sum;
  logic [DW-1:0]      dig_q, dig_new;
  logic [3:0][AW-1:0] rd_idx;
  logic [3:0][W-1:0]  rd_word;
  logic               xor_en, buf_we;
  logic [1:0]         rnd;
  logic [4:0]         rot_a, rot_b;
  logic [31:0]        kc, xw;

  assign buf_we = !busy_q && !start_i && blk_valid_i;

  hash_msg_buf #(.W(W), .DEPTH(NWORDS), .RP(4)) u_buf (
    .clk(clk), .we(buf_we), .waddr(wcnt), .wdata(blk_word_i),
    .raddr(rd_idx), .rdata(rd_word)
  );

  hash_sched #(.STEP_W(STEP_W), .AW(AW)) u_sched (
    .alg(alg_q), .step(step), .rd_idx(rd_idx), .xor_en(xor_en),
    .rnd(rnd), .rot_a(rot_a), .rot_b(rot_b), .kc(kc)
  );

  assign xw = xor_en ? (rd_word[0] ^ rd_word[1] ^ rd_word[2] ^ rd_word[3]) : rd_word[0];

  hash_step u_step (
    .alg(alg_q), .rnd(rnd), .rot_a(rot_a), .rot_b(rot_b), .kc(kc),
    .xw(xw), .cur(work), .nxt(nxt)
  );

  assign last_step = (alg_q == ALG_HAS) ? STEP_W'(HAS_STEPS - 1) : STEP_W'(MD5_STEPS - 1);

  always_comb begin
    for (int n = 0; n < 5; n++) sum[n] = chain[n] + nxt[n];
    if (alg_q == ALG_HAS)
      dig_new = {bswap32(sum[0]), bswap32(sum[1]), bswap32(sum[2]),
                 bswap32(sum[3]), bswap32(sum[4])};
    else
      dig_new = {32'h0, bswap32(sum[0]), bswap32(sum[1]),
                 bswap32(sum[2]), bswap32(sum[3])};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alg_q  <= ALG_MD5;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      last_q <= 1'b0;
      wcnt   <= '0;
      step   <= '0;
      chain  <= '0;
      work   <= '0;
      dig_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          alg_q <= alg_e'(mode_i);
          wcnt  <= '0;
          for (int n = 0; n < 5; n++) chain[n] <= iv_word(alg_e'(mode_i), n);
        end else if (blk_valid_i) begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == AW'(NWORDS - 1)) begin
            busy_q <= 1'b1;
            step   <= '0;
            last_q <= blk_last_i;
            work   <= chain;
          end
        end
      end else begin
        work <= nxt;
        step <= step + 1'b1;
        if (step == last_step) begin
          busy_q <= 1'b0;
          chain  <= sum;
          if (last_q) begin
            done_q <= 1'b1;
            dig_q  <= dig_new;
          end
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign digest_o = dig_q;
endmodule

// File: rtl/hash_dual_core_chk.sv
module hash_dual_core_chk (
  input logic         clk,
  input logic         rst,
  input logic         busy,
  input logic         done,
  input logic [159:0] digest,
  input logic         alg_has
);
  logic [7:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) bcnt <= '0;
    else     bcnt <= busy ? bcnt + 8'd1 : 8'd0;
  end

  assert_busy_len_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (bcnt == (alg_has ? 8'd80 : 8'd64)));

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  assert_digest_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(digest));

  assert_md5_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (done && !alg_has) |-> (digest[159:128] == 32'h0));
endmodule

bind hash_dual_core hash_dual_core_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy_o), .done(done_o),
  .digest(digest_o), .alg_has(alg_q)
);

// File: tb/tb_hash_dual_core.sv
module tb_hash_dual_core;
  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 1'b0, mode_i = 1'b0, blk_valid_i = 1'b0, blk_last_i = 1'b0;
  logic [31:0] blk_word_i = '0;
  logic busy_o, done_o;
  logic [159:0] digest_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hash_dual_core dut (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .blk_valid_i(blk_valid_i), .blk_word_i(blk_word_i), .blk_last_i(blk_last_i),
    .busy_o(busy_o), .done_o(done_o), .digest_o(digest_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0]  pad [256];
  int          nblk;
  logic [31:0] rh [5];
  logic [31:0] mw [16];

  int md5_s [16] = '{7,12,17,22, 5,9,14,20, 4,11,16,23, 6,10,15,21};
  int hs1 [20] = '{5,11,7,15,6,13,8,14,7,12,9,11,8,15,6,12,9,14,5,13};
  int hs2 [4]  = '{10,17,25,30};
  int ho0 [20] = '{18,0,1,2,3,19,4,5,6,7,16,8,9,10,11,17,12,13,14,15};
  int ho1 [20] = '{18,3,6,9,12,19,15,2,5,8,16,11,14,1,4,17,7,10,13,0};
  int ho2 [20] = '{18,12,5,14,7,19,0,9,2,11,16,4,13,6,15,17,8,1,10,3};
  int ho3 [20] = '{18,7,2,13,8,19,3,14,9,4,16,15,10,5,0,17,11,6,1,12};
  logic [31:0] hk [4] = '{32'h0, 32'h5a827999, 32'h6ed9eba1, 32'h8f1bbcdc};

  function automatic logic [31:0] rl(input logic [31:0] x, input int s);
    return (x << s) | (x >> (32 - s));
  endfunction

  function automatic logic [31:0] bs(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic int hord(input int r, input int j);
    case (r)
      0: return ho0[j];
      1: return ho1[j];
      2: return ho2[j];
      default: return ho3[j];
    endcase
  endfunction

  task automatic ref_md5_blk();
    logic [31:0] a, b, c, d, f, t, kk;
    int g;
    real sv;
    a = rh[0]; b = rh[1]; c = rh[2]; d = rh[3];
    for (int i = 0; i < 64; i++) begin
      case (i / 16)
        0: begin f = (b & c) | (~b & d); g = i; end
        1: begin f = (d & b) | (~d & c); g = (5 * i + 1) % 16; end
        2: begin f = b ^ c ^ d;          g = (3 * i + 5) % 16; end
        default: begin f = c ^ (b | ~d); g = (7 * i) % 16; end
      endcase
      sv = $sin(real'(i + 1));
      if (sv < 0.0) sv = -sv;
      kk = 32'(longint'($floor(sv * 4294967296.0)));
      t = a + f + kk + mw[g];
      a = d; d = c; c = b;
      b = b + rl(t, md5_s[(i / 16) * 4 + (i % 4)]);
    end
    rh[0] += a; rh[1] += b; rh[2] += c; rh[3] += d;
  endtask

  task automatic ref_has_blk();
    logic [31:0] a, b, c, d, e, f, t;
    logic [31:0] x [20];
    int seq [16];
    int kx;
    a = rh[0]; b = rh[1]; c = rh[2]; d = rh[3]; e = rh[4];
    for (int r = 0; r < 4; r++) begin
      kx = 0;
      for (int j = 0; j < 20; j++)
        if (hord(r, j) < 16) begin seq[kx] = hord(r, j); kx++; end
      for (int n = 0; n < 16; n++) x[n] = mw[n];
      for (int q = 0; q < 4; q++)
        x[16 + q] = mw[seq[4*q]] ^ mw[seq[4*q+1]] ^ mw[seq[4*q+2]] ^ mw[seq[4*q+3]];
      for (int j = 0; j < 20; j++) begin
        case (r)
          0: f = (b & c) | (~b & d);
          2: f = c ^ (b | ~d);
          default: f = b ^ c ^ d;
        endcase
        t = rl(a, hs1[j]) + f + e + x[hord(r, j)] + hk[r];
        e = d; d = c; c = rl(b, hs2[r]); b = a; a = t;
      end
    end
    rh[0] += a; rh[1] += b; rh[2] += c; rh[3] += d; rh[4] += e;
  endtask

  // kind 0: arithmetic byte pattern; kind 1: "abc"
  task automatic build(input int kind, input int len);
    int total;
    longint bits;
    for (int k = 0; k < 256; k++) pad[k] = 8'h00;
    for (int k = 0; k < len; k++)
      pad[k] = (kind == 1) ? 8'(8'h61 + k) : 8'(k * 37 + len * 11 + 5);
    pad[len] = 8'h80;
    total = ((len + 8) / 64 + 1) * 64;
    bits = longint'(len) * 8;
    for (int k = 0; k < 8; k++) pad[total - 8 + k] = 8'(bits >> (8 * k));
    nblk = total / 64;
  endtask

  function automatic logic [31:0] wd(input int b, input int i);
    int base;
    base = 64 * b + 4 * i;
    return {pad[base+3], pad[base+2], pad[base+1], pad[base]};
  endfunction

  task automatic ref_digest(input bit md, output logic [159:0] dg);
    rh[0] = 32'h67452301; rh[1] = 32'hefcdab89; rh[2] = 32'h98badcfe;
    rh[3] = 32'h10325476; rh[4] = 32'hc3d2e1f0;
    for (int b = 0; b < nblk; b++) begin
      for (int i = 0; i < 16; i++) mw[i] = wd(b, i);
      if (md) ref_has_blk(); else ref_md5_blk();
    end
    if (md) dg = {bs(rh[0]), bs(rh[1]), bs(rh[2]), bs(rh[3]), bs(rh[4])};
    else    dg = {32'h0, bs(rh[0]), bs(rh[1]), bs(rh[2]), bs(rh[3])};
  endtask

  // ---------------- driver ----------------
  task automatic run(input bit md, input int kind, input int len, input bit disturb,
                     output logic [159:0] got);
    logic [159:0] exp, held;
    int cyc, nst;
    string tag;
    build(kind, len);
    ref_digest(md, exp);
    nst = md ? 80 : 64;
    @(negedge clk);
    start_i = 1'b1; mode_i = md;
    @(negedge clk);
    start_i = 1'b0; mode_i = ~md;                      // R5: late mode change ignored
    for (int b = 0; b < nblk; b++) begin
      for (int i = 0; i < 16; i++) begin
        blk_valid_i = 1'b1; blk_word_i = wd(b, i); blk_last_i = (b == nblk - 1);
        @(negedge clk);
      end
      cyc = 0;
      while (busy_o && cyc < 200) begin
        cyc++;
        blk_valid_i = disturb;                          // R8: ignored while busy
        blk_word_i  = 32'(cyc * 32'h9e3779b9);
        start_i     = disturb && (cyc == 5);
        @(negedge clk);
      end
      blk_valid_i = 1'b0; start_i = 1'b0; blk_last_i = 1'b0;
      chk(cyc == nst, "R6", "busy cycles", 160'(cyc), 160'(nst));
      chk(done_o == (b == nblk - 1), "R7", "done after final step",
          160'(done_o), 160'(b == nblk - 1));
    end
    got = digest_o;
    tag = md ? "R3" : "R2";
    if (nblk > 1) tag = {tag, "/R4"};
    if (disturb) tag = {tag, "/R8"};
    chk(got == exp, {tag, "/R5/R10"}, "digest", got, exp);
    held = digest_o;
    @(negedge clk);
    chk(done_o == 1'b0, "R7", "done single pulse", 160'(done_o), 160'(0));
    repeat (2) @(negedge clk);
    chk(digest_o == held, "R9", "digest held", digest_o, held);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [159:0] d;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R1", "busy in reset", 160'(busy_o), 160'(0));
    chk(done_o == 1'b0, "R1", "done in reset", 160'(done_o), 160'(0));
    chk(digest_o == '0, "R1", "digest in reset", digest_o, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0 && digest_o == '0, "R1", "after reset",
        {busy_o, done_o, digest_o[157:0]}, '0);

    run(1'b0, 0, 0, 1'b0, d);
    chk(d == {32'h0, 128'hd41d8cd98f00b204e9800998ecf8427e}, "R2", "MD5 empty known answer",
        d, {32'h0, 128'hd41d8cd98f00b204e9800998ecf8427e});
    run(1'b0, 1, 3, 1'b0, d);
    chk(d == {32'h0, 128'h900150983cd24fb0d6963f7d28e17f72}, "R2", "MD5 abc known answer",
        d, {32'h0, 128'h900150983cd24fb0d6963f7d28e17f72});
    run(1'b1, 0, 0, 1'b0, d);
    chk(d == 160'h307964ef34151d37c8047adec7ab50f4ff89762d, "R3", "HAS-160 empty known answer",
        d, 160'h307964ef34151d37c8047adec7ab50f4ff89762d);

    for (int len = 0; len <= 130; len++)
      for (int m = 0; m < 2; m++)
        run(m[0], 0, len, (len % 5) == 2, d);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    finished = 1;
    $finish;
  end
endmodule